// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the pipeline of a small in-order CPU core. It decides, every cycle, whether a general exception, a non-maskable interrupt or a maskable interrupt is taken, and it keeps the status word (with its block bit) and the two save registers that hold the return address and the saved status word. When an event is taken it reports the event kind, redirects fetch to a vector address provided by the pipeline, saves the status word, sets the block bit, and records the return address. The return address depends on the event type and on delay slots.

While the block bit is set, a general exception that is not a user break forces a manual reset with a fixed cause code. A maskable interrupt is held pending. An NMI is either held or taken, as a software setting selects. In sleep or standby an interrupt is taken regardless of the block bit. A return request copies the saved return address to the fetch redirect and the saved status word back into the status word. The pipeline uses a separate output to suppress the link-register write of a subroutine branch whose delay slot faults.

Top module: `exc_ctrl`

## Requirements
- R1: A general exception with `gexc_ubrk`=0 while the block bit (SR bit 28) is 1 raises `mreset_req` in the same cycle, with `mreset_cause`=0x20, `redirect_pc`=RESET_VEC and `evt_kind`=0. SR then reloads SR_RST, and SPC and SSR keep their values.
- R2: A maskable interrupt while the block bit is 1 and not in sleep is not taken (`evt_kind`=0). It is taken in the first cycle after the block bit has been cleared.
- R3: An NMI while the block bit is 1 and not in sleep is held when `nmi_hold_en`=1 and taken when `nmi_hold_en`=0.
- R4: With `sleep_st`=1, an interrupt or NMI is taken even when the block bit is 1.
- R5: A re-execution type general exception (`gexc_reexec`=1) loads SPC with `cur_pc`, also when the faulting instruction is in a delay slot.
- R6: A completion type general exception, an NMI or an interrupt loads SPC with `next_pc`, or with `br_target` when `in_dbranch`=1.
- R7: `pr_wr_inhibit` is 1 exactly when a general exception with `gexc_reexec`=1 and `in_dslot`=1 is present.
- R8: When an event is taken, `redirect_valid`=1 and `redirect_pc`=`vector_pc` in that cycle. On the next cycle SSR holds the prior SR and SR has its block bit set. `evt_kind` encodes 0 none, 1 general exception, 2 NMI, 3 interrupt.
- R9: Priority is general exception, then NMI, then interrupt, and at most one event is taken per cycle.
- R10: A return request with no event present gives `redirect_valid`=1 and `redirect_pc`=SPC, and SR is then loaded from SSR. An event in the same cycle takes precedence over the return.
- R11: `irq_pend`/`nmi_pend` are 1 in the cycle after a request that was not taken. They are 0 after the request is taken or withdrawn.
- R12: After reset, SR=SR_RST (block bit 1), SPC=0, SSR=0 and both pending flags are 0.
- R13: A user-break general exception (`gexc_ubrk`=1) while the block bit is 1 is taken normally, with no manual reset.
- R14: `sr_wr_en` loads SR from `sr_wr_data` when no event and no return is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| gexc_req | input | 1 | General exception present |
| gexc_reexec | input | 1 | 1 re-execution type, 0 completion type |
| gexc_ubrk | input | 1 | The exception is a user break |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| nmi_hold_en | input | 1 | Hold NMI while block bit set |
| sleep_st | input | 1 | Core in sleep or standby |
| cur_pc | input | AW | PC of current instruction |
| next_pc | input | AW | PC of following instruction |
| br_target | input | AW | Destination of current delayed branch |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| in_dbranch | input | 1 | Current instruction is a delayed branch |
| vector_pc | input | AW | Handler address for taken events |
| rte_req | input | 1 | Return-from-exception request |
| sr_wr_en | input | 1 | Software SR write |
| sr_wr_data | input | SRW | SR write value |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | AW | Redirect address |
| mreset_req | output | 1 | Manual reset request |
| mreset_cause | output | 32 | Cause code, 0x20 with manual reset else 0 |
| pr_wr_inhibit | output | 1 | Suppress branch link write |
| evt_kind | output | 2 | Event taken this cycle |
| irq_pend | output | 1 | Interrupt held pending |
| nmi_pend | output | 1 | NMI held pending |
| sr_out | output | SRW | Status word |
| spc_out | output | AW | Saved return address |
| ssr_out | output | SRW | Saved status word |

## Verification
The assertions watch the block-bit rules on every cycle. A blocked general exception must always raise the manual reset, and a blocked interrupt or held NMI must never be taken. They also check that at most one event is taken per cycle, that taking an event saves SR and sets the block bit, that a return restores SR from SSR, and that a re-execution exception captures the current PC. Several behaviours show only in bench scenarios: the return-address choices across delay-slot and branch combinations, an interrupt held across the cycle that clears the block bit and taken just after it, pending flags clearing on withdrawal, and SPC and SSR surviving a manual reset.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_GEXC = 2'd1,
    EV_NMI  = 2'd2,
    EV_IRQ  = 2'd3
  } ev_kind_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gexc_req,
  input  logic       gexc_ubrk,
  input  logic       irq_req,
  input  logic       nmi_req,
  input  logic       nmi_hold_en,
  input  logic       sleep_st,
  input  logic       bl,
  output logic       acc_gexc,
  output logic       acc_nmi,
  output logic       acc_irq,
  output logic       mreset,
  output logic [1:0] kind,
  output logic       irq_pend_q,
  output logic       nmi_pend_q
);
  logic nmi_gate, irq_gate;

  assign nmi_gate = !bl || !nmi_hold_en || sleep_st;
  assign irq_gate = !bl || sleep_st;

  assign mreset   = gexc_req && bl && !gexc_ubrk;
  assign acc_gexc = gexc_req && !mreset;
  assign acc_nmi  = !gexc_req && nmi_req && nmi_gate;
  assign acc_irq  = !gexc_req && !acc_nmi && irq_req && irq_gate;

  always_comb begin
    if (acc_gexc)     kind = EV_GEXC;
    else if (acc_nmi) kind = EV_NMI;
    else if (acc_irq) kind = EV_IRQ;
    else              kind = EV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      irq_pend_q <= irq_req && !acc_irq;
      nmi_pend_q <= nmi_req && !acc_nmi;
    end
  end

  // R9: single event per cycle
  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mreset, acc_gexc, acc_nmi, acc_irq}));

  // R3: held NMI is never taken
  a_r3_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && bl && nmi_hold_en && !sleep_st) |-> !acc_nmi);
endmodule

// File: rtl/exc_spc_sel.sv
module exc_spc_sel #(
  parameter int AW = 32
) (
  input  logic          reexec_gexc,
  input  logic          in_dbranch,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] next_pc,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] spc_new
);
  function automatic logic [AW-1:0] pick_return(
    input logic          reexec,
    input logic          dbr,
    input logic [AW-1:0] cur,
    input logic [AW-1:0] nxt,
    input logic [AW-1:0] tgt
  );
    if (reexec) return cur;   // rerun faulting or delay-slot instruction
    if (dbr)    return tgt;   // resume at branch destination
    return nxt;
  endfunction

  assign spc_new = pick_return(reexec_gexc, in_dbranch, cur_pc, next_pc, br_target);
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int             AW     = 32,
  parameter int             SRW    = 32,
  parameter int             BL_BIT = 28,
  parameter logic [SRW-1:0] SR_RST = 32'h7000_00F0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           mreset,
  input  logic           rte_do,
  input  logic           sr_wr_en,
  input  logic [SRW-1:0] sr_wr_data,
  input  logic [AW-1:0]  spc_new,
  output logic [SRW-1:0] sr_q,
  output logic [AW-1:0]  spc_q,
  output logic [SRW-1:0] ssr_q
);
  localparam logic [SRW-1:0] BL_MASK = {{(SRW-1){1'b0}}, 1'b1} << BL_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= SR_RST;
      spc_q <= '0;
      ssr_q <= '0;
    end else if (mreset) begin
      sr_q <= SR_RST;
    end else if (take) begin
      ssr_q <= sr_q;
      spc_q <= spc_new;
      sr_q  <= sr_q | BL_MASK;
    end else if (rte_do) begin
      sr_q <= ssr_q;
    end else if (sr_wr_en) begin
      sr_q <= sr_wr_data;
    end
  end

  // R8: entry saves status and blocks further events
  a_r8_entry_save: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sr_q[BL_BIT] && ssr_q == $past(sr_q)));

  // R10: return restores status
  a_r10_rte_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_do && !take && !mreset) |=> sr_q == $past(ssr_q));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int             AW           = 32,
  parameter int             SRW          = 32,
  parameter int             BL_BIT       = 28,
  parameter logic [SRW-1:0] SR_RST       = 32'h7000_00F0,
  parameter logic [AW-1:0]  RESET_VEC    = 32'hA000_0000,
  parameter logic [31:0]    CAUSE_MRESET = 32'h0000_0020
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gexc_req,
  input  logic           gexc_reexec,
  input  logic           gexc_ubrk,
  input  logic           irq_req,
  input  logic           nmi_req,
  input  logic           nmi_hold_en,
  input  logic           sleep_st,
  input  logic [AW-1:0]  cur_pc,
  input  logic [AW-1:0]  next_pc,
  input  logic [AW-1:0]  br_target,
  input  logic           in_dslot,
  input  logic           in_dbranch,
  input  logic [AW-1:0]  vector_pc,
  input  logic           rte_req,
  input  logic           sr_wr_en,
  input  logic [SRW-1:0] sr_wr_data,
  output logic           redirect_valid,
  output logic [AW-1:0]  redirect_pc,
  output logic           mreset_req,
  output logic [31:0]    mreset_cause,
  output logic           pr_wr_inhibit,
  output logic [1:0]     evt_kind,
  output logic           irq_pend,
  output logic           nmi_pend,
  output logic [SRW-1:0] sr_out,
  output logic [AW-1:0]  spc_out,
  output logic [SRW-1:0] ssr_out
);
  logic          acc_gexc, acc_nmi, acc_irq, mreset;
  logic          take, rte_do, bl;
  logic [AW-1:0] spc_new;
  logic [SRW-1:0] sr_q, ssr_q;
  logic [AW-1:0]  spc_q;

  assign bl     = sr_q[BL_BIT];
  assign take   = acc_gexc || acc_nmi || acc_irq;
  assign rte_do = rte_req && !take && !mreset;

  exc_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .gexc_req   (gexc_req),
    .gexc_ubrk  (gexc_ubrk),
    .irq_req    (irq_req),
    .nmi_req    (nmi_req),
    .nmi_hold_en(nmi_hold_en),
    .sleep_st   (sleep_st),
    .bl         (bl),
    .acc_gexc   (acc_gexc),
    .acc_nmi    (acc_nmi),
    .acc_irq    (acc_irq),
    .mreset     (mreset),
    .kind       (evt_kind),
    .irq_pend_q (irq_pend),
    .nmi_pend_q (nmi_pend)
  );

  exc_spc_sel #(.AW(AW)) u_spc (
    .reexec_gexc(acc_gexc && gexc_reexec),
    .in_dbranch (in_dbranch),
    .cur_pc     (cur_pc),
    .next_pc    (next_pc),
    .br_target  (br_target),
    .spc_new    (spc_new)
  );

  exc_state #(.AW(AW), .SRW(SRW), .BL_BIT(BL_BIT), .SR_RST(SR_RST)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .mreset    (mreset),
    .rte_do    (rte_do),
    .sr_wr_en  (sr_wr_en),
    .sr_wr_data(sr_wr_data),
    .spc_new   (spc_new),
    .sr_q      (sr_q),
    .spc_q     (spc_q),
    .ssr_q     (ssr_q)
  );

  always_comb begin
    if (mreset)    redirect_pc = RESET_VEC;
    else if (take) redirect_pc = vector_pc;
    else           redirect_pc = spc_q;
  end

  assign redirect_valid = mreset || take || rte_do;
  assign mreset_req     = mreset;
  assign mreset_cause   = mreset ? CAUSE_MRESET : 32'h0;
  assign pr_wr_inhibit  = gexc_req && gexc_reexec && in_dslot;
  assign sr_out         = sr_q;
  assign spc_out        = spc_q;
  assign ssr_out        = ssr_q;

  // R1: blocked general exception always resets
  a_r1_blocked_gexc: assert property (@(posedge clk) disable iff (!rst_n)
    (gexc_req && sr_out[BL_BIT] && !gexc_ubrk) |-> (mreset_req && redirect_pc == RESET_VEC));

  // R2: blocked interrupt is not taken outside sleep
  a_r2_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && sr_out[BL_BIT] && !sleep_st && !nmi_req && !gexc_req) |-> evt_kind == EV_NONE);

  // R5: re-execution exception captures current PC
  a_r5_reexec_spc: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_kind == EV_GEXC && gexc_reexec) |=> spc_out == $past(cur_pc));
endmodule

// File: tb/exc_ctrl_bench.sv
module exc_ctrl_bench;
  localparam logic [31:0] SR_RST  = 32'h7000_00F0;
  localparam logic [31:0] SR_RUN  = 32'h6000_00F0;
  localparam logic [31:0] SR_BL   = 32'h7000_00F0;
  localparam logic [31:0] RST_VEC = 32'hA000_0000;
  localparam logic [31:0] CUR     = 32'h0000_0100;
  localparam logic [31:0] NXT     = 32'h0000_0104;
  localparam logic [31:0] TGT     = 32'h0000_0200;
  localparam logic [31:0] VEC     = 32'h0000_0800;
  // {gexc, reexec, irq, nmi, dslot, dbranch, kind[1:0], spc_sel[1:0] (0 cur,1 next,2 target), inhibit}
  localparam int NV = 9;
  localparam logic [10:0] TABLE [NV] = '{
    {6'b110000, 2'd1, 2'd0, 1'b0},
    {6'b110010, 2'd1, 2'd0, 1'b1},
    {6'b100001, 2'd1, 2'd2, 1'b0},
    {6'b100000, 2'd1, 2'd1, 1'b0},
    {6'b001000, 2'd3, 2'd1, 1'b0},
    {6'b001001, 2'd3, 2'd2, 1'b0},
    {6'b001100, 2'd2, 2'd1, 1'b0},
    {6'b111110, 2'd1, 2'd0, 1'b1},
    {6'b000101, 2'd2, 2'd2, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic gexc_req = 0, gexc_reexec = 0, gexc_ubrk = 0, irq_req = 0, nmi_req = 0;
  logic nmi_hold_en = 1, sleep_st = 0, in_dslot = 0, in_dbranch = 0, rte_req = 0, sr_wr_en = 0;
  logic [31:0] sr_wr_data = 0;
  logic        redirect_valid, mreset_req, pr_wr_inhibit, irq_pend, nmi_pend;
  logic [31:0] redirect_pc, mreset_cause, sr_out, spc_out, ssr_out;
  logic [1:0]  evt_kind;
  int checks = 0, failures = 0;
  logic [10:0] v;
  logic [31:0] exp_spc, saved_spc, saved_ssr;

  always #2 clk = ~clk;

  exc_ctrl u_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .gexc_req(gexc_req), .gexc_reexec(gexc_reexec),
    .gexc_ubrk(gexc_ubrk), .irq_req(irq_req), .nmi_req(nmi_req), .nmi_hold_en(nmi_hold_en),
    .sleep_st(sleep_st), .cur_pc(CUR), .next_pc(NXT), .br_target(TGT),
    .in_dslot(in_dslot), .in_dbranch(in_dbranch), .vector_pc(VEC), .rte_req(rte_req),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .mreset_req(mreset_req), .mreset_cause(mreset_cause),
    .pr_wr_inhibit(pr_wr_inhibit), .evt_kind(evt_kind), .irq_pend(irq_pend),
    .nmi_pend(nmi_pend), .sr_out(sr_out), .spc_out(spc_out), .ssr_out(ssr_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    gexc_req = 0; gexc_reexec = 0; gexc_ubrk = 0; irq_req = 0; nmi_req = 0;
    in_dslot = 0; in_dbranch = 0; rte_req = 0; sr_wr_en = 0; sleep_st = 0; nmi_hold_en = 1;
  endtask

  task automatic write_sr(input logic [31:0] val);
    sr_wr_en = 1; sr_wr_data = val;
    step();
    sr_wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R12 sr", sr_out, SR_RST);
    chk("R12 spc", spc_out, 0);
    chk("R12 ssr", ssr_out, 0);
    chk("R12 pend", {30'd0, irq_pend, nmi_pend}, 0);

    // R14 software write clears the block bit
    write_sr(SR_RUN);
    chk("R14 sr write", sr_out, SR_RUN);

    for (int k = 0; k < NV; k++) begin
      v = TABLE[k];
      gexc_req = v[10]; gexc_reexec = v[9]; irq_req = v[8]; nmi_req = v[7];
      in_dslot = v[6]; in_dbranch = v[5];
      #1;
      chk("R9 kind", {30'd0, evt_kind}, {30'd0, v[4:3]});
      chk("R8 redirect", redirect_pc, VEC);
      chk("R7 inhibit", {31'd0, pr_wr_inhibit}, {31'd0, v[0]});
      step();
      idle();
      chk("R8 bl set", sr_out, SR_BL);
      chk("R8 ssr", ssr_out, SR_RUN);
      exp_spc = (v[2:1] == 2'd0) ? CUR : (v[2:1] == 2'd1) ? NXT : TGT;
      chk(v[2:1] == 2'd0 ? "R5 spc" : "R6 spc", spc_out, exp_spc);
      rte_req = 1;
      #1;
      chk("R10 valid", {31'd0, redirect_valid}, 1);
      chk("R10 pc", redirect_pc, exp_spc);
      step();
      rte_req = 0;
      chk("R10 sr", sr_out, SR_RUN);
    end

    // R2 held while blocked, taken once cleared
    write_sr(SR_BL);
    irq_req = 1;
    #1;
    chk("R2 held", {30'd0, evt_kind}, 0);
    step();
    chk("R11 irq pend", {31'd0, irq_pend}, 1);
    sr_wr_en = 1; sr_wr_data = SR_RUN;
    #1;
    chk("R2 held in clearing cycle", {30'd0, evt_kind}, 0);
    step();
    sr_wr_en = 0;
    #1;
    chk("R2 taken after clear", {30'd0, evt_kind}, 3);
    step();
    irq_req = 0;
    chk("R11 pend cleared on take", {31'd0, irq_pend}, 0);

    // R11 withdrawal clears pending (block bit now 1)
    irq_req = 1;
    step();
    chk("R11 pend set", {31'd0, irq_pend}, 1);
    irq_req = 0;
    step();
    chk("R11 pend withdrawn", {31'd0, irq_pend}, 0);

    // R3 NMI hold selection
    nmi_req = 1; nmi_hold_en = 1;
    #1;
    chk("R3 nmi held", {30'd0, evt_kind}, 0);
    step();
    chk("R11 nmi pend", {31'd0, nmi_pend}, 1);
    nmi_hold_en = 0;
    #1;
    chk("R3 nmi taken", {30'd0, evt_kind}, 2);
    step();
    idle();
    chk("R11 nmi pend cleared", {31'd0, nmi_pend}, 0);

    // R4 sleep accepts despite block bit
    chk("R4 precondition bl", {31'd0, sr_out[28]}, 1);
    sleep_st = 1; irq_req = 1;
    #1;
    chk("R4 sleep irq", {30'd0, evt_kind}, 3);
    step();
    idle();

    // R13 user break while blocked
    gexc_req = 1; gexc_ubrk = 1; gexc_reexec = 1;
    #1;
    chk("R13 no reset", {31'd0, mreset_req}, 0);
    chk("R13 kind", {30'd0, evt_kind}, 1);
    step();
    idle();

    // R1 manual reset
    saved_spc = spc_out; saved_ssr = ssr_out;
    gexc_req = 1;
    #1;
    chk("R1 mreset", {31'd0, mreset_req}, 1);
    chk("R1 cause", mreset_cause, 32'h20);
    chk("R1 pc", redirect_pc, RST_VEC);
    chk("R1 kind", {30'd0, evt_kind}, 0);
    step();
    idle();
    chk("R1 sr", sr_out, SR_RST);
    chk("R1 spc kept", spc_out, saved_spc);
    chk("R1 ssr kept", ssr_out, saved_ssr);

    // R10 event beats return
    write_sr(SR_RUN);
    rte_req = 1; irq_req = 1;
    #1;
    chk("R10 event wins kind", {30'd0, evt_kind}, 3);
    chk("R10 event wins pc", redirect_pc, VEC);
    step();
    idle();
    chk("R10 event wins ssr", ssr_out, SR_RUN);

    // R12 reset mid-run
    rst_n = 0;
    step();
    rst_n = 1;
    step();
    chk("R12 sr again", sr_out, SR_RST);
    chk("R12 spc again", spc_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule